// File: doc/BRIEF.md
# DDFS Phase Accumulator and Half-Wave Folder

This block produces the digital phase for a direct digital frequency synthesiser. It has no lookup table. On every clock a 20-bit phase register advances by a frequency control word and wraps modulo 2^20. The output frequency is therefore the control word times the clock frequency divided by 2^20, and the tuning step is finer than one part per million of the clock. Only the upper 11 bits of the phase go downstream. The most significant of them folds the other ten by half-wave symmetry: in the second half of each period those ten bits are inverted, so the folded phase climbs to its maximum and then retraces its path back down.

The folded 10-bit value is split into two codes. The upper 4 bits form a coarse code, which tells a 16-cell thermometer-decoded converter how many cells are fully on. The lower 6 bits form a fine code, which sets the level of a small linear phase converter that interpolates the next cell. Both codes leave the block from registers and move in the same cycle. A new control word is captured in a holding register first. The phase is never cleared when the word changes.

Top module: `ddfs_phase_core`

## Requirements
- R1: While `rst` is high at a clock edge, the phase register, the held control word and both output codes are cleared to zero. After release with a zero control word, both codes stay at zero.
- R2: The phase register is 20 bits wide and wraps modulo 2^20. A control word of 0xFFFFF steps the phase backwards by one count per cycle.
- R3: `fcw_i` is captured on a clock edge and is first added to the phase at the following edge. Changing it never clears the accumulated phase.
- R4: Only phase bits 19..9 reach the outputs. With a control word of 1, the codes stay at zero for the first 512 accumulated counts.
- R5: With p = phase[19:9], the folded value f[9:0] equals p[9:0] when p[10] is 0 and the bitwise inverse of p[9:0] when p[10] is 1.
- R6: `coarse_o` is f[9:6] and `fine_o` is f[5:0]. Both are registered, take the folded value of the phase held before the edge, and change in the same cycle.
- R7: With a control word of 512 (2^9), p advances by exactly one per cycle. The concatenated codes then count up from 0 to 1023, hold 1023 for two cycles across the half-period, and count back down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | 20 | Frequency control word |
| coarse_o | output | 4 | Number of fully-on thermometer cells |
| fine_o | output | 6 | Interpolation level for the next cell |

## Verification
A control-word change and a phase wrap or half-period fold can land in the same cycle. In that cycle the held word, the old phase and the fold direction all meet at the output register. The bench provokes this by changing the word on every cycle while it runs near-full-scale and half-scale words, which force the top phase bit to toggle and the register to wrap often. A bench model advances its own copy of the holding register, accumulator and output stage at each edge. The codes are compared against that model on every cycle, so a word applied one edge early or late, or a lost phase, shows up as a mismatch at the fold point.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;
    localparam int ACC_W    = 20;
    localparam int PHASE_W  = 11;
    localparam int COARSE_W = 4;
    localparam int FOLD_W   = PHASE_W - 1;
    localparam int FINE_W   = FOLD_W - COARSE_W;
    localparam int DROP_W   = ACC_W - PHASE_W;

    typedef logic [ACC_W-1:0]   acc_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } codes_t;

    // Expected codes for a truncated phase, written by half selection
    function automatic codes_t expect_codes(input phase_t p);
        logic [FOLD_W-1:0] lo;
        lo = p[FOLD_W-1:0];
        if (p[PHASE_W-1]) return codes_t'(~lo);
        else              return codes_t'(lo);
    endfunction
endpackage

// File: rtl/ddfs_fcw_hold.sv
module ddfs_fcw_hold
    import ddfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t word_i,
    output acc_t word_o
);
    always_ff @(posedge clk) begin
        if (rst) word_o <= '0;
        else     word_o <= word_i;
    end
endmodule

// File: rtl/ddfs_phase_acc.sv
module ddfs_phase_acc
    import ddfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t step_i,
    output acc_t phase_o
);
    acc_t sum;

    always_comb sum = phase_o + step_i;   // carry out of the top bit is dropped

    always_ff @(posedge clk) begin
        if (rst) phase_o <= '0;
        else     phase_o <= sum;
    end
endmodule

// File: rtl/ddfs_phase_fold.sv
module ddfs_phase_fold
    import ddfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  acc_t   phase_i,
    output codes_t codes_o
);
    phase_t            trunc;
    logic [FOLD_W-1:0] folded;

    always_comb trunc = phase_i[ACC_W-1:DROP_W];

    for (genvar b = 0; b < FOLD_W; b++) begin : g_xor
        assign folded[b] = trunc[b] ^ trunc[PHASE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) codes_o <= '0;
        else     codes_o <= codes_t'(folded);
    end
endmodule

// File: rtl/ddfs_phase_core.sv
module ddfs_phase_core
    import ddfs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ACC_W-1:0]    fcw_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [FINE_W-1:0]   fine_o
);
    acc_t   fcw_q;
    acc_t   phase_q;
    codes_t codes_q;

    ddfs_fcw_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .word_i (fcw_i),
        .word_o (fcw_q)
    );

    ddfs_phase_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (fcw_q),
        .phase_o (phase_q)
    );

    ddfs_phase_fold u_fold (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_q),
        .codes_o (codes_q)
    );

    assign coarse_o = codes_q.coarse;
    assign fine_o   = codes_q.fine;

    // R1: one cycle after reset all state is zero
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (phase_q == '0 && fcw_q == '0 && coarse_o == '0 && fine_o == '0));

    // R3: held word follows the port with one edge of delay
    a_r3_word_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> fcw_q == $past(fcw_i));

    // R2: phase advances by the held word modulo 2^ACC_W
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc_t'(phase_q - $past(phase_q)) == $past(fcw_q));

    // R5: in the second half the coarse code mirrors the raw bits
    a_r5_mirror: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_q[ACC_W-1]))
            |-> coarse_o == ~$past(phase_q[ACC_W-2 -: COARSE_W]));

    // R6: both codes come from the phase held one edge earlier
    a_r6_codes_track: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> {coarse_o, fine_o} == expect_codes($past(phase_q[ACC_W-1:DROP_W])));
endmodule

// File: tb/tb_ddfs_phase_core.sv
module tb_ddfs_phase_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] fcw_i = '0;
    logic [3:0]  coarse_o;
    logic [5:0]  fine_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [19:0] m_fcw, m_acc;
    logic [9:0]  m_codes;

    always #5 clk = ~clk;

    ddfs_phase_core dut (
        .clk      (clk),
        .rst      (rst),
        .fcw_i    (fcw_i),
        .coarse_o (coarse_o),
        .fine_o   (fine_o)
    );

    function automatic logic [9:0] fold_ref(input logic [19:0] acc);
        logic [10:0] p;
        p = acc[19:9];
        return p[10] ? ~p[9:0] : p[9:0];
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (coarse_o !== m_codes[9:6] || fine_o !== m_codes[5:0]) begin
            n_fail++;
            $display("FAIL %s: coarse=%0d fine=%0d expected coarse=%0d fine=%0d",
                     tag, coarse_o, fine_o, m_codes[9:6], m_codes[5:0]);
        end
    endtask

    // check now, then advance the model across the next edge
    task automatic step(input logic [19:0] w, input string tag);
        check(tag);
        m_codes = fold_ref(m_acc);
        m_acc   = m_acc + m_fcw;
        m_fcw   = w;
        fcw_i   = w;
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        rst   = 1'b1;
        fcw_i = 20'hABCDE;
        repeat (cycles) @(negedge clk);
        m_fcw = '0; m_acc = '0; m_codes = '0;
        check("R1 reset");
        fcw_i = '0;
        rst   = 1'b0;
    endtask

    task automatic run();
        logic [19:0] w;
        int          hold;
        @(negedge clk);
        do_reset(3);
        for (int i = 0; i < 5; i++) step('0, "R1 idle");
        // R4: sub-LSB accumulation does not reach the codes
        for (int i = 0; i < 520; i++) step(20'd1, "R4 low bits");
        do_reset(2);
        // R7: one phase count per cycle across both halves
        for (int i = 0; i < 2100; i++) step(20'd512, "R7 ramp");
        // R2: wrap with backward and near-half steps
        for (int i = 0; i < 300; i++) step(20'hFFFFF, "R2 wrap");
        for (int i = 0; i < 300; i++) step(20'h80001, "R2 wrap");
        // R3: word changes every cycle, phase never cleared
        for (int i = 0; i < 1500; i++) begin
            w = $urandom();
            if (i % 4 == 0) w = 20'hFFFFF - (w & 20'h000FF);
            step(w, "R3 change");
        end
        // R5/R6: random words held for random lengths
        for (int i = 0; i < 100; i++) begin
            w    = $urandom();
            hold = 1 + ($urandom() % 30);
            for (int j = 0; j < hold; j++) step(w, "R5 R6 fold");
        end
        do_reset(1);
        step('0, "R1 after run");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_fcw = '0; m_acc = '0; m_codes = '0;
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule